// File: doc/BRIEF.md
# ADC Sample Packer with Byte-Wide Readback

This block sits between the sampling front end of a single-channel pulse-echo receiver and the host's 8-bit serial link. On the write side it takes one 10-bit converter sample per strobe. It packs that sample, with a 2-bit cycle index and two external marker inputs, into one 16-bit word. The word is written to an external sample memory at an address that increments on every write.

On the read side the host clocks in a filler byte, which the block sees as a one-cycle byte request. The block answers each request with one byte. While an acquisition is running, the answer is a fixed busy marker. Otherwise the block returns the stored words in address order, the upper byte of each word first. Every byte carries an identification bit in bit 7, so a host that has lost count can realign.

A memory-reset strobe sends both pointers back to address 0. The block keeps no record of how many words hold valid data. A host that reads further than the data it wrote gets whatever the memory still contains.

Top module: `sample_pack_readback`

## Requirements
- R1: A byte request made while `acq_busy` is high is answered with 0xAA. It leaves the read pointer and the byte phase unchanged.
- R2: The upper byte of a stored word has bit 7 = 1. Bits 6:5 hold the cycle index, bits 4:3 hold the markers (`wr_marks[1]` in bit 4), and bits 2:0 hold ADC bits 9:7.
- R3: The lower byte of a stored word has bit 7 = 0, and bits 6:0 hold ADC bits 6:0.
- R4: Each byte request is answered in the following cycle with `rd_valid` high for one cycle. `rd_valid` stays low in any cycle that does not follow a request.
- R5: When the block is not busy, requests return the upper byte and then the lower byte of each word. Words are returned in increasing address order, starting from address 0.
- R6: Each `wr_valid` strobe produces exactly one memory write in the next cycle. The write carries the packed word of R2/R3 and goes to the next sequential address, starting at 0.
- R7: A `mem_clear` strobe returns both pointers to address 0 and makes the next non-busy byte an upper byte. It has priority: a request or write strobe in the same cycle is dropped.
- R8: The read pointer and the write pointer each wrap from DEPTH-1 back to 0.
- R9: A read beyond the last written word returns the raw contents of that memory word, with no marking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acq_busy | input | 1 | Acquisition in progress |
| mem_clear | input | 1 | Memory-reset strobe |
| wr_valid | input | 1 | Sample strobe |
| wr_adc | input | 10 | Converter sample |
| wr_cycle | input | 2 | Cycle index of the current line |
| wr_marks | input | 2 | External marker inputs |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | 16 | Packed word to memory |
| mem_raddr | output | AW | Memory read address (synchronous memory, one-cycle latency) |
| mem_rdata | input | 16 | Memory read data |
| rd_req | input | 1 | One-cycle byte request from the serial side |
| rd_valid | output | 1 | Byte response valid |
| rd_byte | output | 8 | Byte response |

## Verification
The write port is registered, so the memory write for a strobe taken at edge N is visible between edges N and N+1. The bench samples it at the falling edge after edge N. Byte answers follow the same one-edge rule, and the bench reads each one at the falling edge that follows the edge that took the request. A new read address reaches `mem_rdata` only one edge later. For that reason the bench leaves two idle cycles after every clear or change of busy before it issues the next upper-byte request. Inputs change only on falling edges, so no check depends on the order of events at a rising edge.

// File: rtl/spk_pkg.sv
package spk_pkg;

  localparam logic [7:0] BUSY_MARK = 8'hAA;

  typedef enum logic {HALF_HI = 1'b0, HALF_LO = 1'b1} half_e;

  typedef struct packed {
    logic [9:0] adc;
    logic [1:0] cyc;
    logic [1:0] marks;
  } sample_t;

  // upper byte: tag 1, cycle, markers, adc[9:7]; lower byte: tag 0, adc[6:0]
  function automatic logic [15:0] pack_word(sample_t s);
    return {1'b1, s.cyc, s.marks, s.adc[9:7], 1'b0, s.adc[6:0]};
  endfunction

endpackage

// File: rtl/spk_rst_sync.sv
module spk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/spk_packer.sv
module spk_packer
  import spk_pkg::*;
#(
  parameter int DEPTH = 524288,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_valid,
  input  sample_t       wr_sample,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [15:0]   mem_wdata
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic          we_q, we_d;
  logic [AW-1:0] waddr_q, waddr_d;
  logic [15:0]   wdata_q, wdata_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    we_d     = 1'b0;
    waddr_d  = waddr_q;
    wdata_d  = wdata_q;
    if (clear) begin
      wr_ptr_d = '0;
    end else if (wr_valid) begin
      we_d     = 1'b1;
      waddr_d  = wr_ptr_q;
      wdata_d  = pack_word(wr_sample);
      wr_ptr_d = (wr_ptr_q == LAST_ADDR) ? '0 : wr_ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      we_q     <= we_d;
      waddr_q  <= waddr_d;
      wdata_q  <= wdata_d;
    end
  end

  assign mem_we    = we_q;
  assign mem_waddr = waddr_q;
  assign mem_wdata = wdata_q;

  // R6: an accepted strobe yields one tagged write in the next cycle
  p_write_tagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !clear |=> mem_we && mem_wdata[15] && !mem_wdata[7]);

  // R6: consecutive writes go to consecutive addresses
  p_write_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !clear && wr_ptr_q != LAST_ADDR |=> wr_ptr_q == $past(wr_ptr_q) + AW'(1));

  // R7: clear wins over a write strobe
  p_write_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !mem_we && wr_ptr_q == '0);

  // R8: write pointer wraps
  p_write_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !clear && wr_ptr_q == LAST_ADDR |=> wr_ptr_q == '0);

endmodule

// File: rtl/spk_read_ctrl.sv
module spk_read_ctrl
  import spk_pkg::*;
#(
  parameter int DEPTH = 524288,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          acq_busy,
  input  logic          rd_req,
  output logic [AW-1:0] mem_raddr,
  input  logic [15:0]   mem_rdata,
  output logic          rd_valid,
  output logic [7:0]    rd_byte
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_d;
  half_e         half_q, half_d;
  logic [7:0]    hold_q, hold_d;
  logic          valid_q, valid_d;
  logic [7:0]    byte_q, byte_d;
  logic          take_hi, take_lo;

  assign take_hi = rd_req && !clear && !acq_busy && (half_q == HALF_HI);
  assign take_lo = rd_req && !clear && !acq_busy && (half_q == HALF_LO);

  always_comb begin
    ptr_d   = ptr_q;
    half_d  = half_q;
    hold_d  = hold_q;
    valid_d = 1'b0;
    byte_d  = byte_q;
    if (clear) begin
      ptr_d  = '0;
      half_d = HALF_HI;
    end else if (rd_req) begin
      valid_d = 1'b1;
      if (acq_busy) begin
        byte_d = BUSY_MARK;
      end else if (half_q == HALF_HI) begin
        byte_d = mem_rdata[15:8];
        hold_d = mem_rdata[7:0];
        half_d = HALF_LO;
        ptr_d  = (ptr_q == LAST_ADDR) ? '0 : ptr_q + AW'(1);
      end else begin
        byte_d = hold_q;
        half_d = HALF_HI;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      half_q  <= HALF_HI;
      hold_q  <= '0;
      valid_q <= 1'b0;
      byte_q  <= '0;
    end else begin
      ptr_q   <= ptr_d;
      half_q  <= half_d;
      hold_q  <= hold_d;
      valid_q <= valid_d;
      byte_q  <= byte_d;
    end
  end

  assign mem_raddr = ptr_q;
  assign rd_valid  = valid_q;
  assign rd_byte   = byte_q;

  // R1: busy answer and no state movement
  p_busy_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && acq_busy && !clear |=> rd_valid && rd_byte == BUSY_MARK);
  p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && acq_busy && !clear |=> $stable(ptr_q) && $stable(half_q));

  // R4: one answer per request, none otherwise
  p_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !clear |=> rd_valid);
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req || clear |=> !rd_valid);

  // R5: upper byte then lower byte; lower byte keeps the address
  p_hi_then_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_hi |=> half_q == HALF_LO);
  p_lo_then_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_lo |=> half_q == HALF_HI && $stable(ptr_q));

  // R7: clear resets the pointer and the phase
  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> ptr_q == '0 && half_q == HALF_HI && !rd_valid);

  // R8: read pointer wraps
  p_read_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_hi && ptr_q == LAST_ADDR |=> ptr_q == '0);

endmodule

// File: rtl/sample_pack_readback.sv
module sample_pack_readback
  import spk_pkg::*;
#(
  parameter int DEPTH = 524288,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq_busy,
  input  logic          mem_clear,
  input  logic          wr_valid,
  input  logic [9:0]    wr_adc,
  input  logic [1:0]    wr_cycle,
  input  logic [1:0]    wr_marks,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [15:0]   mem_wdata,
  output logic [AW-1:0] mem_raddr,
  input  logic [15:0]   mem_rdata,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [7:0]    rd_byte
);

  logic    rst_n_sync;
  sample_t sample;

  assign sample = '{adc: wr_adc, cyc: wr_cycle, marks: wr_marks};

  spk_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  spk_packer #(.DEPTH(DEPTH), .AW(AW)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .clear     (mem_clear),
    .wr_valid  (wr_valid),
    .wr_sample (sample),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata)
  );

  spk_read_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_read (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .clear     (mem_clear),
    .acq_busy  (acq_busy),
    .rd_req    (rd_req),
    .mem_raddr (mem_raddr),
    .mem_rdata (mem_rdata),
    .rd_valid  (rd_valid),
    .rd_byte   (rd_byte)
  );

endmodule

// File: tb/sim_sample_pack_readback.sv
module sim_sample_pack_readback;

  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          acq_busy, mem_clear, wr_valid, rd_req;
  logic [9:0]    wr_adc;
  logic [1:0]    wr_cycle, wr_marks;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [15:0]   mem_wdata, mem_rdata;
  logic          rd_valid;
  logic [7:0]    rd_byte;

  logic [15:0] mem [DEPTH];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // {adc, cycle, marks, expected upper byte, expected lower byte}
  localparam logic [29:0] VEC [8] = '{
    {10'h000, 2'd0, 2'd0, 8'h80, 8'h00},
    {10'h3FF, 2'd3, 2'd3, 8'hFF, 8'h7F},
    {10'h155, 2'd1, 2'd2, 8'hB2, 8'h55},
    {10'h2AA, 2'd2, 2'd1, 8'hCD, 8'h2A},
    {10'h080, 2'd0, 2'd0, 8'h81, 8'h00},
    {10'h07F, 2'd3, 2'd0, 8'hE0, 8'h7F},
    {10'h200, 2'd0, 2'd1, 8'h8C, 8'h00},
    {10'h123, 2'd1, 2'd0, 8'hA2, 8'h23}
  };

  sample_pack_readback #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .acq_busy(acq_busy), .mem_clear(mem_clear),
    .wr_valid(wr_valid), .wr_adc(wr_adc), .wr_cycle(wr_cycle), .wr_marks(wr_marks),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_byte(rd_byte)
  );

  // synchronous memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
    mem_rdata <= mem[mem_raddr];
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_byte(output logic v, output logic [7:0] b);
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    v = rd_valid;
    b = rd_byte;
  endtask

  task automatic write_sample(logic [9:0] a, logic [1:0] c, logic [1:0] m);
    @(negedge clk);
    wr_valid = 1'b1; wr_adc = a; wr_cycle = c; wr_marks = m;
    @(negedge clk) wr_valid = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk) mem_clear = 1'b1;
    @(negedge clk) mem_clear = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic v;
    logic [7:0] b;
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'h5A00 | 16'(i);
    rst_n = 1'b0;
    acq_busy = 1'b0; mem_clear = 1'b0; wr_valid = 1'b0; rd_req = 1'b0;
    wr_adc = '0; wr_cycle = '0; wr_marks = '0;
    repeat (3) @(negedge clk);
    check("R4 reset rd_valid", 32'(rd_valid), 0);
    check("R6 reset mem_we", 32'(mem_we), 0);
    check("R5 reset read address", 32'(mem_raddr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    do_clear();
    acq_busy = 1'b1;
    for (int i = 0; i < 8; i++) begin
      write_sample(VEC[i][29:20], VEC[i][19:18], VEC[i][17:16]);
      check("R6 write enable", 32'(mem_we), 1);
      check("R6 write address", 32'(mem_waddr), 32'(i));
      check("R2 R3 packed word", 32'(mem_wdata), 32'(VEC[i][15:0]));
    end
    @(negedge clk);
    check("R6 single write per strobe", 32'(mem_we), 0);

    read_byte(v, b);
    check("R1 busy valid", 32'(v), 1);
    check("R1 busy marker", 32'(b), 32'hAA);
    acq_busy = 1'b0;
    @(negedge clk);
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      read_byte(v, b);
      check("R4 answer valid", 32'(v), 1);
      check("R2 R5 upper byte", 32'(b), 32'(VEC[i][15:8]));
      read_byte(v, b);
      check("R3 R5 lower byte", 32'(b), 32'(VEC[i][7:0]));
    end
    @(negedge clk);
    check("R4 no answer without request", 32'(rd_valid), 0);

    read_byte(v, b);
    check("R9 stale upper byte", 32'(b), 32'h5A);
    read_byte(v, b);
    check("R9 stale lower byte", 32'(b), 32'h08);

    do_clear();
    read_byte(v, b);
    check("R7 restart at word 0", 32'(b), 32'h80);
    do_clear();
    read_byte(v, b);
    check("R7 clear mid-word forces upper byte", 32'(b), 32'h80);
    acq_busy = 1'b1;
    read_byte(v, b);
    check("R1 busy mid-word", 32'(b), 32'hAA);
    acq_busy = 1'b0;
    @(negedge clk);
    read_byte(v, b);
    check("R1 phase kept through busy", 32'(b), 32'h00);
    read_byte(v, b);
    check("R1 pointer kept through busy", 32'(b), 32'hFF);

    @(negedge clk);
    mem_clear = 1'b1; rd_req = 1'b1; wr_valid = 1'b1;
    @(negedge clk);
    mem_clear = 1'b0; rd_req = 1'b0; wr_valid = 1'b0;
    check("R7 request dropped on clear", 32'(rd_valid), 0);
    check("R7 write dropped on clear", 32'(mem_we), 0);
    @(negedge clk);
    @(negedge clk);
    read_byte(v, b);
    check("R7 no skew after dropped read", 32'(b), 32'h80);

    do_clear();
    for (int i = 0; i < 2 * DEPTH; i++) read_byte(v, b);
    read_byte(v, b);
    check("R8 read pointer wraps", 32'(b), 32'h80);

    do_clear();
    for (int i = 0; i < DEPTH; i++) write_sample(10'h001, 2'd0, 2'd0);
    write_sample(10'h002, 2'd0, 2'd0);
    check("R8 write pointer wraps", 32'(mem_waddr), 0);

    finish_run();
  end

endmodule